// File: doc/BRIEF.md
# Raw I/Q Frame Position Adapter

This block sits between a 16-bit, one-word-per-clock I/Q datapath on the line side and a legacy "raw" user interface. On the raw interface every word carries a position count that gives its place inside the basic frame. The line supplies a frame-start pulse, a transmit-enable strobe, a receive word and a line-rate select. The block keeps one position counter for each direction. For the selected rate it sets the frame length, it zeroes the control-word bit positions in the transmit stream, and it aligns the receive word with its count.

The transmit count leads its data by one clock. The user reads the count in one cycle and drives the matching word, and the word is taken at the next rising edge. The receive count and the receive word appear together in the same cycle, one clock after the word reached the line input. On the line, bits [7:0] of a word are the byte that goes first. The block passes words through whole, so the low-byte-first order is kept in both directions.

Neither side has a ready signal and neither side can apply back-pressure. The line runs at a fixed word rate, so the user must supply a transmit word in every cycle and must accept a receive word in every cycle. The receive-valid strobe marks frame alignment only; it is not a handshake.

Top module: `raw_iq_adapter`

## Requirements
- R1: While reset is low, every output is zero.
- R2: A rate select of 0, 1, 2, 3, 4 or 5 sets the frame length to 8, 16, 32, 40, 64 or 80 clocks. The receive count is 0 in the cycle after a cycle with frame_start_i high, then increases by 1 each clock, and returns to 0 after it reaches length minus 1.
- R3: The transmit count goes to 0 in the cycle after a cycle with frame_start_i high. Otherwise it advances by 1, wrapping after length minus 1, only in the cycle after a cycle with tx_enable_i high, and holds its value in every other cycle.
- R4: The word present on line_rx_i in cycle t appears on rx_data_o in cycle t+1, together with its position on rx_count_o.
- R5: When the rate select is valid, rx_valid_o is high exactly in the cycles where rx_count_o is 0. The one exception is the first cycle after reset, where the count is 0 and rx_valid_o is low.
- R6: line_tx_o in cycle t+1 equals the tx_data_i word driven in cycle t, the cycle in which tx_count_o showed that word's position.
- R7: Transmit control-word positions are driven as zero on line_tx_o. Fully reserved counts are none for select 0, count 0 for select 1, counts 0–1 for selects 2 and 3, counts 0–3 for select 4 and counts 0–4 for select 5. In addition, bits [7:0] are reserved at count 0 for select 0 and at count 2 for select 3.
- R8: Receive control-word positions are passed to rx_data_o unchanged.
- R9: A rate select from 6 to 15 forces both counts to 0, rx_valid_o low and line_tx_o to zero from the following cycle onward.
- R10: If the rate select changes while a count is at or above the new length minus 1, that counter returns to 0 on its next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | Pulse on the first word of a basic frame |
| tx_enable_i | input | 1 | Strobe that advances the transmit count |
| rate_sel_i | input | 4 | Line-rate select, 0..5 valid |
| line_rx_i | input | 16 | Receive word from the line |
| line_tx_o | output | 16 | Transmit word to the line, control-word bits zeroed |
| tx_data_i | input | 16 | User transmit word for the position shown on tx_count_o |
| tx_count_o | output | 7 | Transmit position in the basic frame |
| rx_data_o | output | 16 | Receive word for the user |
| rx_count_o | output | 7 | Receive position, aligned with rx_data_o |
| rx_valid_o | output | 1 | High at receive position 0 |

## Verification
Some properties are checked on every cycle: that each counter reloads on frame start and wraps at the end of the frame, that the transmit count holds while the enable is low, that fully and half reserved transmit slots reach the line as zeros, that an invalid select zeroes the line output, and that the valid strobe never appears away from position 0. Other behaviour is shown only by the bench sweep across all six rates and the invalid codes: the frame length that belongs to each select value, the one-cycle lead of the transmit count over its data, the alignment of the receive word with its count, the unchanged passage of receive control words, and the wrap to 0 after a downward rate change.

// File: rtl/raw_iq_pkg.sv
package raw_iq_pkg;
  localparam int CNT_W = 7;
  localparam int SEL_W = 4;
  localparam int NUM_RATES = 6;

  typedef struct packed {
    logic             ok;
    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] full_cw;
    logic             half_cw;
  } rate_cfg_t;

  function automatic rate_cfg_t decode_rate(input logic [SEL_W-1:0] sel);
    rate_cfg_t c;
    c.ok      = 1'b1;
    c.half_cw = 1'b0;
    case (sel)
      4'd0: begin c.len = CNT_W'(8);  c.full_cw = CNT_W'(0); c.half_cw = 1'b1; end
      4'd1: begin c.len = CNT_W'(16); c.full_cw = CNT_W'(1); end
      4'd2: begin c.len = CNT_W'(32); c.full_cw = CNT_W'(2); end
      4'd3: begin c.len = CNT_W'(40); c.full_cw = CNT_W'(2); c.half_cw = 1'b1; end
      4'd4: begin c.len = CNT_W'(64); c.full_cw = CNT_W'(4); end
      4'd5: begin c.len = CNT_W'(80); c.full_cw = CNT_W'(5); end
      default: begin c.ok = 1'b0; c.len = CNT_W'(1); c.full_cw = CNT_W'(0); end
    endcase
    return c;
  endfunction
endpackage

// File: rtl/raw_iq_rate_decode.sv
module raw_iq_rate_decode
  import raw_iq_pkg::*;
(
  input  logic [SEL_W-1:0] rate_sel_i,
  output rate_cfg_t        cfg_o
);
  always_comb cfg_o = decode_rate(rate_sel_i);
endmodule

// File: rtl/raw_iq_pos_counter.sv
module raw_iq_pos_counter
  import raw_iq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q >= (len_i - CNT_W'(1)));

  always_comb begin
    if (clr_i || load_i)  cnt_d = '0;
    else if (adv_i)       cnt_d = at_end ? '0 : cnt_q + CNT_W'(1);
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;

  // R2: frame start reloads the count
  a_r2_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == '0));
  // R2: with a steady length the count stays inside the frame
  a_r2_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q < len_i) |=> ((cnt_q < len_i) || !$stable(len_i)));
  // R3: no enable, no frame start, no clear: count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !load_i && !clr_i) |=> $stable(cnt_q));
  // R10: at or past the last position an advance returns to 0
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && (cnt_q >= (len_i - CNT_W'(1)))) |=> (cnt_q == '0));
  // R9: an invalid rate clears the count
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/raw_iq_tx_path.sv
module raw_iq_tx_path
  import raw_iq_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  rate_cfg_t         cfg_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [DATA_W-1:0] line_tx_o
);
  localparam int NBYTES = DATA_W / 8;

  logic              slot_full, slot_half;
  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] line_q;

  assign slot_full = (count_i < cfg_i.full_cw);
  assign slot_half = cfg_i.half_cw && (count_i == cfg_i.full_cw);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic kill;
    if (b == 0) begin : g_low
      assign kill = slot_full || slot_half;
    end else begin : g_high
      assign kill = slot_full;
    end
    assign masked[b*8 +: 8] = kill ? 8'h00 : tx_data_i[b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         line_q <= '0;
    else if (!cfg_i.ok) line_q <= '0;
    else                line_q <= masked;
  end

  assign line_tx_o = line_q;

  // R7: fully reserved slot reaches the line as zero
  a_r7_full_zero: assert property (@(posedge clk) disable iff (!rst_n)
    slot_full |=> (line_tx_o == '0));
  // R7: half reserved slot has its low byte zeroed
  a_r7_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
    slot_half |=> (line_tx_o[7:0] == 8'h00));
  // R9: invalid select drives zero on the line
  a_r9_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.ok |=> (line_tx_o == '0));
endmodule

// File: rtl/raw_iq_rx_path.sv
module raw_iq_rx_path
  import raw_iq_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  rate_cfg_t         cfg_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [CNT_W-1:0]  count_next_i,
  input  logic [DATA_W-1:0] line_rx_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o
);
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      data_q  <= line_rx_i;
      valid_q <= cfg_i.ok && (count_next_i == '0);
    end
  end

  assign rx_data_o  = data_q;
  assign rx_valid_o = valid_q;

  // R5: the valid strobe only ever marks position 0
  a_r5_valid_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (count_i == '0));
  // R9: no strobe after an invalid select
  a_r9_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.ok |=> !rx_valid_o);
endmodule

// File: rtl/raw_iq_adapter.sv
module raw_iq_adapter
  import raw_iq_pkg::*;
#(
  parameter int DATA_W = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start_i,
  input  logic              tx_enable_i,
  input  logic [3:0]        rate_sel_i,
  input  logic [DATA_W-1:0] line_rx_i,
  output logic [DATA_W-1:0] line_tx_o,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic [6:0]        tx_count_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [6:0]        rx_count_o,
  output logic              rx_valid_o
);
  rate_cfg_t        cfg;
  logic [CNT_W-1:0] tx_cnt, tx_cnt_next;
  logic [CNT_W-1:0] rx_cnt, rx_cnt_next;

  raw_iq_rate_decode u_decode (
    .rate_sel_i (rate_sel_i),
    .cfg_o      (cfg)
  );

  raw_iq_pos_counter u_tx_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (!cfg.ok),
    .load_i     (frame_start_i),
    .adv_i      (tx_enable_i),
    .len_i      (cfg.len),
    .cnt_o      (tx_cnt),
    .cnt_next_o (tx_cnt_next)
  );

  raw_iq_pos_counter u_rx_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (!cfg.ok),
    .load_i     (frame_start_i),
    .adv_i      (1'b1),
    .len_i      (cfg.len),
    .cnt_o      (rx_cnt),
    .cnt_next_o (rx_cnt_next)
  );

  raw_iq_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_i     (cfg),
    .count_i   (tx_cnt),
    .tx_data_i (tx_data_i),
    .line_tx_o (line_tx_o)
  );

  raw_iq_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg),
    .count_i      (rx_cnt),
    .count_next_i (rx_cnt_next),
    .line_rx_i    (line_rx_i),
    .rx_data_o    (rx_data_o),
    .rx_valid_o   (rx_valid_o)
  );

  assign tx_count_o = tx_cnt;
  assign rx_count_o = rx_cnt;

  wire unused_tx_next = ^tx_cnt_next;
endmodule

// File: tb/raw_iq_adapter_tb.sv
module raw_iq_adapter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0, en = 1'b0;
  logic [3:0]  rate = 4'd0;
  logic [15:0] rxw = '0, txw = '0;
  logic [15:0] line_tx, rx_data;
  logic [6:0]  tx_count, rx_count;
  logic        rx_valid;

  int checks = 0, fails = 0, cyc_no = 0;
  int e_rx = 0, e_tx = 0;
  logic        e_val = 1'b0;
  logic [15:0] e_line = '0, e_rxd = '0;
  string       line_tag = "R6", rxd_tag = "R4";

  always #4 clk = ~clk;

  raw_iq_adapter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start_i(fs), .tx_enable_i(en),
    .rate_sel_i(rate), .line_rx_i(rxw), .line_tx_o(line_tx),
    .tx_data_i(txw), .tx_count_o(tx_count), .rx_data_o(rx_data),
    .rx_count_o(rx_count), .rx_valid_o(rx_valid)
  );

  function automatic int flen(input int r);
    case (r)
      0: return 8;  1: return 16; 2: return 32;
      3: return 40; 4: return 64; 5: return 80;
      default: return 1;
    endcase
  endfunction

  function automatic int fullcw(input int r);
    case (r)
      0: return 0; 1: return 1; 2: return 2;
      3: return 2; 4: return 4; 5: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic bit halfcw(input int r, input int c);
    return (r == 0 && c == 0) || (r == 3 && c == 2);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, cyc_no, act, exp);
    end
  endtask

  // drive inputs at a falling edge, let one rising edge pass, check at next falling edge
  task automatic step(input logic f, input logic e, input logic [15:0] rw, input logic [15:0] tw);
    int r, l, nrx, ntx;
    bit vr;
    fs = f; en = e; rxw = rw; txw = tw;
    r = int'(rate); vr = (r < 6); l = flen(r);
    nrx = !vr ? 0 : f ? 0 : ((e_rx + 1 >= l) ? 0 : e_rx + 1);
    ntx = !vr ? 0 : f ? 0 : !e ? e_tx : ((e_tx + 1 >= l) ? 0 : e_tx + 1);
    if (!vr) begin
      e_line = '0; line_tag = "R9";
    end else if (e_tx < fullcw(r)) begin
      e_line = '0; line_tag = "R7";
    end else if (halfcw(r, e_tx)) begin
      e_line = {tw[15:8], 8'h00}; line_tag = "R7";
    end else begin
      e_line = tw; line_tag = "R6";
    end
    rxd_tag = (vr && (e_rx < fullcw(r) || halfcw(r, e_rx))) ? "R8" : "R4";
    e_rxd = rw;
    e_rx = nrx; e_tx = ntx;
    e_val = vr && (nrx == 0);
    @(negedge clk);
    cyc_no++;
    chk(vr ? "R2 rx_count" : "R9 rx_count", int'(rx_count), e_rx);
    chk(vr ? "R3 tx_count" : "R9 tx_count", int'(tx_count), e_tx);
    chk(vr ? "R5 rx_valid" : "R9 rx_valid", int'(rx_valid), int'(e_val));
    chk(line_tag, int'(line_tx), int'(e_line));
    chk(rxd_tag, int'(rx_data), int'(e_rxd));
  endtask

  function automatic logic [15:0] pat_rx(input int t);
    return 16'(t * 16'h1357) ^ 16'hA5C3;
  endfunction
  function automatic logic [15:0] pat_tx(input int t);
    return 16'(t * 16'h2469) ^ 16'h5A3C;
  endfunction

  initial begin
    int t = 0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk("R1 line_tx", int'(line_tx), 0);
    chk("R1 rx_data", int'(rx_data), 0);
    chk("R1 counts", int'(tx_count) + int'(rx_count), 0);
    chk("R1 rx_valid", int'(rx_valid), 0);
    rst_n = 1'b1;

    // full frames at every valid rate, enable always high
    for (int r = 0; r < 6; r++) begin
      rate = 4'(r);
      for (int f = 0; f < 3; f++)
        for (int i = 0; i < flen(r); i++) begin
          step(i == 0, 1'b1, pat_rx(t), pat_tx(t)); t++;
        end
    end
    // gapped enable and frame starts at an offset from the frame length
    for (int r = 0; r < 6; r++) begin
      rate = 4'(r);
      for (int i = 0; i < 2 * flen(r) + 7; i++) begin
        step((i % (flen(r) + 3)) == 0, (i % 3) != 0, pat_rx(t), pat_tx(t)); t++;
      end
    end
    // invalid select codes
    for (int r = 6; r < 16; r++) begin
      rate = 4'(r);
      for (int i = 0; i < 4; i++) begin
        step(i == 1, 1'b1, pat_rx(t), pat_tx(t)); t++;
      end
    end
    // R10: drop from the longest frame to the shortest in mid-frame
    rate = 4'd5;
    for (int i = 0; i < 72; i++) begin
      step(i == 0, 1'b1, pat_rx(t), pat_tx(t)); t++;
    end
    rate = 4'd0;
    step(1'b0, 1'b1, pat_rx(t), pat_tx(t)); t++;
    chk("R10 rx_count after rate drop", int'(rx_count), 0);
    chk("R10 tx_count after rate drop", int'(tx_count), 0);
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 1'b1, pat_rx(t), pat_tx(t)); t++;
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule